// File: doc/BRIEF.md
# Transport Stream Energy Dispersal Descrambler

This block undoes the energy dispersal applied to a packet-aligned transport stream. One byte arrives per valid cycle, together with a start-of-packet flag and a flag that marks an inverted sync byte. A 15-stage pseudo-random binary sequence generator with the polynomial 1 + x^14 + x^15 produces eight bits per byte. Those bits are XORed into every byte that is not a sync byte.

Sync bytes pass untouched. An inverted sync byte opens a scrambling period that spans eight packets. At that byte the generator is reloaded from a programmable seed, so the first data byte after it is descrambled with the seed state. Each non-inverted sync byte inside the period advances the generator by eight bits and leaves the data alone.

A bypass control lets the stream through unmodified, so descrambling can be done elsewhere. Two registers behind a write-only configuration port hold the bypass bit and the seed. Every output is registered, and the latency is one cycle.

Top module: `ts_descrambler`

## Requirements
- R1: After reset, valid_o is 0, bypass is off and the seed is 0x00A9. Seed bit k holds generator stage k+1, so the stage values from 1 to 15 read 100101010000000. The generator also starts from this value, which makes the first output byte 0x03.
- R2: valid_o, sop_o and inv_sync_o equal valid_i, sop_i and inv_sync_i one clock cycle later.
- R3: A byte that has valid_i and sop_i high leaves on data_o unchanged.
- R4: A valid byte with sop_i low leaves as data_i XOR a PRBS byte. One generator step outputs stage14 XOR stage15 and shifts that bit into stage 1. The first step of a byte gives bit 7 and the eighth step gives bit 0.
- R5: With bypass off, a byte that has sop_i and inv_sync_i high loads the generator from the seed. The next data byte is descrambled with the seed state.
- R6: With bypass off, a sync byte that has inv_sync_i low advances the generator by eight steps without changing the data.
- R7: While bypass is set, every byte leaves unchanged one cycle later and the generator holds its state, even at inverted sync bytes.
- R8: A write with cfg_addr_i=1 stores cfg_wdata_i[14:0] as the seed. A write with cfg_addr_i=0 stores cfg_wdata_i[0] as the bypass bit. A seed write does not touch the running generator.
- R9: A cycle with valid_i low leaves the generator state unchanged and gives valid_o=0 in the next cycle.
- R10: When bypass is cleared, the generator resumes from the state it held when bypass was set. The next inverted sync byte restarts it from the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 1 | Register select: 0 = control, 1 = seed |
| cfg_wdata_i | input | 15 | Configuration write data |
| valid_i | input | 1 | Input byte valid |
| data_i | input | 8 | Input byte |
| sop_i | input | 1 | Byte is a sync byte that starts a packet |
| inv_sync_i | input | 1 | Sync byte arrived inverted |
| valid_o | output | 1 | Output byte valid |
| data_o | output | 8 | Descrambled byte |
| sop_o | output | 1 | Delayed start-of-packet flag |
| inv_sync_o | output | 1 | Delayed inverted-sync flag |

## Verification
The bench runs full eight-packet periods under several seeds, including the all-ones seed and a single-bit seed, with idle gaps placed between bytes. A design that XORs sync bytes, fails to advance the generator on plain sync bytes, or advances it on idle cycles drifts out of step and corrupts every later data byte. Bypass is set and cleared in the middle of a period, and an inverted sync byte is sent while bypass is set. A generator that keeps running or reloads under bypass then produces the wrong bytes when bypass is cleared. The default seed is checked against the literal first byte 0x03, which exposes a reversed bit order within the byte or the wrong tap positions.

// File: rtl/ts_descr_pkg.sv
package ts_descr_pkg;
  localparam int LFSR_W    = 15;
  localparam int BYTE_W    = 8;
  localparam logic [LFSR_W-1:0] SEED_RST = 15'h00A9;

  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_SEED = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/ts_descr_cfg.sv
module ts_descr_cfg
  import ts_descr_pkg::*;
#(
  parameter int                SEED_W  = LFSR_W,
  parameter logic [SEED_W-1:0] SEED_DF = SEED_RST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [SEED_W-1:0] wdata_i,
  output logic              bypass_o,
  output logic [SEED_W-1:0] seed_o
);
  logic we_ctrl, we_seed;
  assign we_ctrl = we_i && (reg_sel_e'(addr_i) == REG_CTRL);
  assign we_seed = we_i && (reg_sel_e'(addr_i) == REG_SEED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bypass_o <= 1'b0;
      seed_o   <= SEED_DF;
    end else begin
      if (we_ctrl) bypass_o <= wdata_i[0];
      if (we_seed) seed_o   <= wdata_i;
    end
  end

  AST_SEED_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_seed) |-> seed_o == $past(wdata_i)); // R8
  AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_ctrl) |-> bypass_o == $past(wdata_i[0])); // R8
endmodule

// File: rtl/ts_prbs_gen.sv
module ts_prbs_gen
  import ts_descr_pkg::*;
#(
  parameter int               W      = LFSR_W,
  parameter int               STEPS  = BYTE_W,
  parameter logic [W-1:0]     RST_ST = SEED_RST
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [W-1:0]     seed_i,
  output logic [STEPS-1:0] prbs_o
);
  localparam int TAP_HI = W - 1;
  localparam int TAP_LO = W - 2;

  logic [W-1:0] state_q;
  logic [W-1:0] chain [STEPS+1];
  logic [STEPS-1:0] fb;

  assign chain[0] = state_q;

  for (genvar k = 0; k < STEPS; k++) begin : g_step
    assign fb[k]         = chain[k][TAP_LO] ^ chain[k][TAP_HI];
    assign chain[k+1]    = {chain[k][W-2:0], fb[k]};
    assign prbs_o[STEPS-1-k] = fb[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= RST_ST;
    else if (load_i) state_q <= seed_i;
    else if (adv_i)  state_q <= chain[STEPS];
  end

  AST_GEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(load_i) && !$past(adv_i)) |-> $stable(state_q)); // R9
  AST_GEN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_i) |-> state_q == $past(seed_i)); // R5
  AST_GEN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && adv_i)); // R5
endmodule

// File: rtl/ts_descrambler.sv
module ts_descrambler
  import ts_descr_pkg::*;
#(
  parameter int                SEED_W  = LFSR_W,
  parameter int                DATA_W  = BYTE_W,
  parameter logic [SEED_W-1:0] SEED_DF = SEED_RST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_addr_i,
  input  logic [SEED_W-1:0] cfg_wdata_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sop_i,
  input  logic              inv_sync_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              sop_o,
  output logic              inv_sync_o
);
  logic              bypass;
  logic [SEED_W-1:0] seed;
  logic [DATA_W-1:0] prbs;
  logic              is_sync, gen_load, gen_adv, do_xor;
  logic              primed_q;

  ts_descr_cfg #(.SEED_W(SEED_W), .SEED_DF(SEED_DF)) i_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .bypass_o (bypass),
    .seed_o   (seed)
  );

  assign is_sync  = valid_i && sop_i;
  assign gen_load = is_sync && inv_sync_i && !bypass;
  assign gen_adv  = valid_i && !bypass && !gen_load;
  assign do_xor   = valid_i && !sop_i && !bypass;

  ts_prbs_gen #(.W(SEED_W), .STEPS(DATA_W), .RST_ST(SEED_DF)) i_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (gen_load),
    .adv_i  (gen_adv),
    .seed_i (seed),
    .prbs_o (prbs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      data_o     <= '0;
      sop_o      <= 1'b0;
      inv_sync_o <= 1'b0;
      primed_q   <= 1'b0;
    end else begin
      valid_o    <= valid_i;
      data_o     <= do_xor ? (data_i ^ prbs) : data_i;
      sop_o      <= sop_i;
      inv_sync_o <= inv_sync_i;
      primed_q   <= 1'b1;
    end
  end

  AST_LAT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q |-> (valid_o == $past(valid_i) && sop_o == $past(sop_i))); // R2
  AST_SYNC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && valid_o && sop_o) |-> data_o == $past(data_i)); // R3
  AST_BYPASS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && valid_o && $past(bypass)) |-> data_o == $past(data_i)); // R7
endmodule

// File: tb/test_ts_descrambler.sv
module test_ts_descrambler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [14:0] cfg_wdata = '0;
  logic        valid_in = 1'b0;
  logic [7:0]  data_in = '0;
  logic        sop_in = 1'b0;
  logic        inv_in = 1'b0;
  logic        valid_out;
  logic [7:0]  data_out;
  logic        sop_out;
  logic        inv_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:1] ms;
  logic [14:0] seed_m = 15'h00A9;
  bit          byp_m = 1'b0;

  always #5 clk = ~clk;

  ts_descrambler i_ts_descrambler (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .valid_i(valid_in), .data_i(data_in),
    .sop_i(sop_in), .inv_sync_i(inv_in), .valid_o(valid_out),
    .data_o(data_out), .sop_o(sop_out), .inv_sync_o(inv_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_byte(output logic [7:0] b);
    logic o;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      o  = ms[14] ^ ms[15];
      ms = {ms[14:1], o};
      b  = {b[6:0], o};
    end
  endtask

  task automatic cfg_write(input logic a, input logic [14:0] d);
    @(negedge clk);
    valid_in = 1'b0; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a) seed_m = d; else byp_m = d[0];
  endtask

  task automatic send(input logic [7:0] d, input bit sop, input bit inv, input string tag);
    logic [7:0] exp, p;
    @(negedge clk);
    valid_in = 1'b1; data_in = d; sop_in = sop; inv_in = inv;
    if (byp_m) exp = d;
    else if (sop) begin
      exp = d;
      if (inv) ms = seed_m; else model_byte(p);
    end else begin
      model_byte(p);
      exp = d ^ p;
    end
    @(posedge clk); #1;
    chk(valid_out && sop_out == sop && inv_out == inv, "R2 flags",
        {valid_out, sop_out, inv_out}, {1'b1, sop, inv});
    chk(data_out == exp, tag, data_out, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_in = 1'b0; sop_in = 1'b0; inv_in = 1'b0; data_in = 8'hFF;
      @(posedge clk); #1;
      chk(!valid_out, "R9 idle valid_o", valid_out, 0);
    end
  endtask

  task automatic period(input int salt, input int gaps);
    for (int p = 0; p < 8; p++) begin
      send(p == 0 ? 8'hB8 : 8'h47, 1'b1, p == 0, p == 0 ? "R5 inv sync" : "R6 sync");
      for (int j = 0; j < 11; j++) begin
        send(8'((salt * 13 + p * 37 + j * 91) & 8'hFF), 1'b0, 1'b0,
             j == 0 && p == 0 ? "R5 first byte" : (p > 0 && j == 0 ? "R6 after sync" : "R4 data"));
        if (gaps != 0 && ((j + p) % gaps) == 0) idle(1);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    ms = 15'h00A9;
    repeat (3) @(negedge clk);
    #1;
    chk(!valid_out, "R1 reset valid_o", valid_out, 0);
    rst_n = 1'b1;
    idle(2);
    // R1 / R4: default state, literal first byte 0x03
    send(8'h00, 1'b0, 1'b0, "R1 default first byte");
    chk(data_out == 8'h03, "R4 literal prbs byte", data_out, 8'h03);
    send(8'h5A, 1'b0, 1'b0, "R4 data");
    // R1: default seed register after inverted sync
    send(8'hB8, 1'b1, 1'b1, "R1 inv sync");
    send(8'h00, 1'b0, 1'b0, "R1 default seed byte");
    chk(data_out == 8'h03, "R1 default seed literal", data_out, 8'h03);
    period(1, 0);
    period(2, 3);
    // R8: other seeds
    cfg_write(1'b1, 15'h0001);
    period(3, 2);
    cfg_write(1'b1, 15'h7FFF);
    period(4, 5);
    cfg_write(1'b1, 15'h4A5B);
    period(5, 0);
    // R7 / R10: bypass in the middle of a period
    send(8'hB8, 1'b1, 1'b1, "R5 inv sync");
    for (int j = 0; j < 5; j++) send(8'(j * 29 + 3), 1'b0, 1'b0, "R4 data");
    cfg_write(1'b0, 15'h0001);
    for (int j = 0; j < 6; j++) send(8'(j * 17 + 1), 1'b0, 1'b0, "R7 bypass data");
    send(8'h47, 1'b1, 1'b0, "R7 bypass sync");
    send(8'hB8, 1'b1, 1'b1, "R7 bypass inv sync");
    for (int j = 0; j < 4; j++) send(8'(j * 71), 1'b0, 1'b0, "R7 bypass data");
    cfg_write(1'b1, 15'h1234); // R8: seed write leaves the generator alone
    cfg_write(1'b0, 15'h0000);
    for (int j = 0; j < 6; j++) send(8'(j * 5 + 9), 1'b0, 1'b0, "R10 resume");
    send(8'h47, 1'b1, 1'b0, "R6 sync");
    send(8'h11, 1'b0, 1'b0, "R10 resume after sync");
    period(6, 4);
    idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule